// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a UART that sits on a plain 32-bit register bus made of an address, a write strobe, a read strobe, write data and combinational read data. Software writes bytes into an 8-entry transmit queue and reads bytes out of an 8-entry receive queue. A serializer sends each byte as one start bit, eight data bits LSB first and one or two stop bits. A deserializer takes incoming frames of the same shape, passes the line through a two-flop synchronizer, and samples each bit near its middle. One 16-bit divisor sets the bit period for both directions.

Two interrupt sources report how full the queues are: transmit space and receive backlog. Each is compared against a 3-bit threshold that software programs. Each source has an enable bit and a pending bit, and the enabled pending bits are ORed onto one level interrupt line. The queue status flag lives in bit 31 of the data registers themselves. A driver can therefore poll and move data with a single access.

Top module: `serial_wm_uart`

## Requirements
- R1: After reset the transmit control (offset 0x08), receive control (0x0C), interrupt enable (0x10) and pending (0x14) registers read 0, the divisor (0x18) reads DIV_RESET (15), `irq` is 0 and `ser_tx` is 1.
- R2: A write to offset 0x00 pushes write-data bits 7:0 into the transmit queue. While bit 0 of 0x08 is 1, each queued byte leaves on `ser_tx` as a low start bit, then eight data bits LSB first, then a high stop bit. The line rests high when idle, and bytes are held in the queue while bit 0 is 0.
- R3: Every bit lasts divisor+1 clock cycles. Back-to-back frames with one stop bit start 10*(divisor+1) cycles apart.
- R4: When bit 1 of 0x08 is 1, frames carry two stop bits, and back-to-back frames start 11*(divisor+1) cycles apart.
- R5: A read of 0x00 returns bit 31 set exactly while the transmit queue holds 8 bytes. A write to 0x00 while the queue is full is dropped.
- R6: A read of 0x04 removes the oldest received byte and returns it in bits 7:0 with bit 31 clear. When the receive queue is empty, bit 31 reads 1 and nothing is removed.
- R7: A frame that completes while the receive queue holds 8 bytes is discarded, and the 8 stored bytes are kept in order.
- R8: Pending bit 0 (0x14) is 1 exactly while the transmit queue occupancy is below 0x08 bits 18:16.
- R9: Pending bit 1 is 1 exactly while the receive queue occupancy is above 0x0C bits 18:16.
- R10: `irq` equals the OR of (enable bits 1:0 of 0x10 AND pending bits 1:0), and writes to 0x14 have no effect.
- R11: While bit 0 of 0x0C is 0, incoming frames are ignored and nothing enters the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of 0x04 pops) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ser_rx | input | 1 | Serial input, asynchronous |
| ser_tx | output | 1 | Serial output |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker checks several properties on every cycle:
- writes and completed frames that arrive at a full queue leave its occupancy unchanged;
- a pop from a non-empty receive queue lowers its occupancy by one;
- the idle serializer holds the line high;
- an interrupt never appears with both enables clear;
- an empty transmit queue raises the transmit pending bit whenever the threshold is non-zero.

Only the bench scenarios show frame contents, bit order, spacing with one and two stop bits, and receive sampling. They also cover overflow ordering, the exact threshold crossings, the disabled receiver, and the fact that writes to the pending register are ignored.

// File: rtl/swu_pkg.sv
package swu_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;
    localparam int WM_W   = 3;
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] OFS_TXQ  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RXQ  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TCFG = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RCFG = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_IPND = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_BAUD = 5'h18;

    typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_e;

    typedef struct packed {
        logic             tx_en;
        logic             two_stop;
        logic [WM_W-1:0]  tx_wm;
        logic             rx_en;
        logic [WM_W-1:0]  rx_wm;
        logic [1:0]       ie;
        logic [DIV_W-1:0] div;
    } ctl_t;
endpackage

// File: rtl/swu_fifo.sv
module swu_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + PW'(1);
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + PW'(1);
        end
        if (do_push && !do_pop) st_d.cnt = st_q.cnt + CW'(1);
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/swu_tx.sv
module swu_tx
    import swu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              two_stop,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              txd,
    output logic              idle
);
    typedef struct packed {
        phase_e            ph;
        logic [DIV_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              second;
        logic              txd;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic tick, start_ok, load;

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        tick     = (st_q.cnt >= div);
        start_ok = en && !fifo_empty;
        if (st_q.ph != PH_IDLE) st_d.cnt = tick ? '0 : st_q.cnt + DIV_W'(1);
        case (st_q.ph)
            PH_IDLE:  load = start_ok;
            PH_START: if (tick) begin
                st_d.ph   = PH_DATA;
                st_d.txd  = st_q.sh[0];
                st_d.sh   = {1'b0, st_q.sh[DATA_W-1:1]};
                st_d.bitn = '0;
            end
            PH_DATA: if (tick) begin
                if (st_q.bitn == BIT_W'(DATA_W - 1)) begin
                    st_d.ph     = PH_STOP;
                    st_d.txd    = 1'b1;
                    st_d.second = 1'b0;
                end else begin
                    st_d.txd  = st_q.sh[0];
                    st_d.sh   = {1'b0, st_q.sh[DATA_W-1:1]};
                    st_d.bitn = st_q.bitn + BIT_W'(1);
                end
            end
            PH_STOP: if (tick) begin
                if (two_stop && !st_q.second) st_d.second = 1'b1;
                else if (start_ok)            load = 1'b1;
                else                          st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
        if (load) begin
            st_d.ph  = PH_START;
            st_d.sh  = fifo_data;
            st_d.txd = 1'b0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop  = load;
    assign txd  = st_q.txd;
    assign idle = (st_q.ph == PH_IDLE);
endmodule

// File: rtl/swu_rx.sv
module swu_rx
    import swu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              rxd_async,
    output logic              push,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        phase_e            ph;
        logic [DIV_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = rxd_async;
        st_d.s2 = st_q.s1;
        push    = 1'b0;
        tick    = (st_q.cnt >= div);
        if (st_q.ph != PH_IDLE) st_d.cnt = st_q.cnt + DIV_W'(1);
        case (st_q.ph)
            PH_IDLE: if (en && !st_q.s2) begin
                st_d.ph  = PH_START;
                st_d.cnt = '0;
            end
            PH_START: if (st_q.cnt >= (div >> 1)) begin
                st_d.cnt  = '0;
                st_d.bitn = '0;
                st_d.ph   = st_q.s2 ? PH_IDLE : PH_DATA;
            end
            PH_DATA: if (tick) begin
                st_d.cnt = '0;
                st_d.sh  = {st_q.s2, st_q.sh[DATA_W-1:1]};
                if (st_q.bitn == BIT_W'(DATA_W - 1)) st_d.ph = PH_STOP;
                else st_d.bitn = st_q.bitn + BIT_W'(1);
            end
            PH_STOP: if (tick) begin
                st_d.cnt = '0;
                st_d.ph  = PH_IDLE;
                push     = st_q.s2;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.s1 <= 1'b1;
            st_q.s2 <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.sh;
endmodule

// File: rtl/serial_wm_uart.sv
module serial_wm_uart
    import swu_pkg::*;
#(
    parameter int               DEPTH     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ser_rx,
    output logic              ser_tx,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    ctl_t ctl_d, ctl_q;
    logic              tx_push, tx_pop, tx_full, tx_empty, tx_idle;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
    logic [1:0]        ip;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[31:19];
    assign tx_push = bus_wr && (bus_addr == OFS_TXQ);
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXQ);

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_TCFG: begin
                    ctl_d.tx_en    = bus_wdata[0];
                    ctl_d.two_stop = bus_wdata[1];
                    ctl_d.tx_wm    = bus_wdata[18:16];
                end
                OFS_RCFG: begin
                    ctl_d.rx_en = bus_wdata[0];
                    ctl_d.rx_wm = bus_wdata[18:16];
                end
                OFS_IEN:  ctl_d.ie  = bus_wdata[1:0];
                OFS_BAUD: ctl_d.div = bus_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.div <= DIV_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ip[0] = (tx_cnt < CW'(ctl_q.tx_wm));
    assign ip[1] = (rx_cnt > CW'(ctl_q.rx_wm));
    assign irq   = |(ctl_q.ie & ip);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TXQ:  bus_rdata[31] = tx_full;
            OFS_RXQ:  bus_rdata = {rx_empty, 23'b0, rx_head};
            OFS_TCFG: bus_rdata = {13'b0, ctl_q.tx_wm, 14'b0, ctl_q.two_stop, ctl_q.tx_en};
            OFS_RCFG: bus_rdata = {13'b0, ctl_q.rx_wm, 15'b0, ctl_q.rx_en};
            OFS_IEN:  bus_rdata = {30'b0, ctl_q.ie};
            OFS_IPND: bus_rdata = {30'b0, ip};
            OFS_BAUD: bus_rdata = {{(32-DIV_W){1'b0}}, ctl_q.div};
            default:  bus_rdata = '0;
        endcase
    end

    swu_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    swu_tx u_ser (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.tx_en), .two_stop(ctl_q.two_stop),
        .div(ctl_q.div), .fifo_empty(tx_empty), .fifo_data(tx_head),
        .pop(tx_pop), .txd(ser_tx), .idle(tx_idle)
    );

    swu_rx u_des (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.rx_en), .div(ctl_q.div),
        .rxd_async(ser_rx), .push(rx_push), .data(rx_byte)
    );

    swu_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: rtl/swu_checker.sv
module swu_checker #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          tx_full,
    input logic [CW-1:0] tx_cnt,
    input logic          tx_idle,
    input logic [2:0]    tx_wm,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_full,
    input logic [CW-1:0] rx_cnt,
    input logic [1:0]    ie,
    input logic [1:0]    ip,
    input logic          ser_tx,
    input logic          irq
);
    // R5
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));

    // R7
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> (rx_cnt == $past(rx_cnt)));

    // R6
    rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && (rx_cnt != '0) && !rx_push) |=> (rx_cnt == $past(rx_cnt) - CW'(1)));

    // R2
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> ser_tx);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b00) |-> !irq);

    // R8
    txwm_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_cnt == '0) && (tx_wm != 3'd0)) |-> ip[0]);
endmodule

bind serial_wm_uart swu_checker #(.CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full),
    .tx_cnt(tx_cnt), .tx_idle(tx_idle), .tx_wm(ctl_q.tx_wm), .rx_push(rx_push),
    .rx_pop(rx_pop), .rx_full(rx_full), .rx_cnt(rx_cnt), .ie(ctl_q.ie), .ip(ip),
    .ser_tx(ser_tx), .irq(irq)
);

// File: tb/serial_wm_uart_tb_top.sv
module serial_wm_uart_tb_top;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_rx = 1'b1;
    logic        ser_tx, irq;

    int          checks = 0, errors = 0;
    longint      cyc = 0, last_start = -1;
    logic [7:0]  txq[$];
    longint      gaps[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_wm_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_rx(ser_rx), .ser_tx(ser_tx), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr32(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd32(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tx_byte(input logic [7:0] b);
        txq.push_back(b);
        wr32(5'h00, {24'b0, b});
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        ser_rx = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            repeat (P) @(negedge clk);
        end
        ser_rx = 1'b1;
        repeat (P) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor: decode ser_tx and compare with the expected queue
    initial begin
        logic [7:0] got;
        logic       stp;
        wait (rst_n);
        forever begin
            @(negedge ser_tx);
            if (last_start >= 0) gaps.push_back(cyc - last_start);
            last_start = cyc;
            repeat (P / 2) @(posedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (P) @(posedge clk);
                #1 got[i] = ser_tx;
            end
            repeat (P) @(posedge clk);
            #1 stp = ser_tx;
            if (txq.size() == 0) begin
                check(1'b0, "R2/R5 unexpected frame", {24'b0, got}, 32'h0);
            end else begin
                logic [7:0] e;
                e = txq.pop_front();
                check(got == e, "R2 frame byte", {24'b0, got}, {24'b0, e});
            end
            check(stp == 1'b1, "R2 stop level", {31'b0, stp}, 32'h1);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd32(5'h08, d); check(d == 32'h0, "R1 tx control", d, 32'h0);
        rd32(5'h0C, d); check(d == 32'h0, "R1 rx control", d, 32'h0);
        rd32(5'h10, d); check(d == 32'h0, "R1 enables", d, 32'h0);
        rd32(5'h14, d); check(d == 32'h0, "R1 pending", d, 32'h0);
        rd32(5'h18, d); check(d == 32'd15, "R1 divisor", d, 32'd15);
        check(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
        check(ser_tx == 1'b1, "R1 line idle", {31'b0, ser_tx}, 32'h1);

        // R2 R3 one stop bit
        wr32(5'h18, 32'd3);
        wr32(5'h08, 32'h1);
        gaps.delete();
        tx_byte(8'hA5); tx_byte(8'h3C); tx_byte(8'hF0);
        repeat (200) @(negedge clk);
        check(txq.size() == 0, "R2 all frames sent", txq.size(), 0);
        check(gaps.size() > 0 && gaps[gaps.size()-1] == 40, "R3 frame spacing",
              (gaps.size() > 0) ? 32'(gaps[gaps.size()-1]) : 32'h0, 32'd40);

        // R4 two stop bits
        wr32(5'h08, 32'h3);
        gaps.delete();
        tx_byte(8'h11); tx_byte(8'h22);
        repeat (200) @(negedge clk);
        check(gaps.size() > 0 && gaps[gaps.size()-1] == 44, "R4 frame spacing",
              (gaps.size() > 0) ? 32'(gaps[gaps.size()-1]) : 32'h0, 32'd44);

        // R8 R10 transmit watermark, transmitter off, threshold 2
        wr32(5'h08, 32'h0002_0000);
        rd32(5'h14, d); check(d == 32'h1, "R8 below threshold", d, 32'h1);
        wr32(5'h10, 32'h1);
        check(irq == 1'b1, "R10 irq enabled", {31'b0, irq}, 32'h1);
        wr32(5'h14, 32'h0);
        rd32(5'h14, d); check(d == 32'h1, "R10 pending write ignored", d, 32'h1);
        check(irq == 1'b1, "R10 irq after pending write", {31'b0, irq}, 32'h1);
        wr32(5'h10, 32'h0);
        check(irq == 1'b0, "R10 irq masked", {31'b0, irq}, 32'h0);
        tx_byte(8'h01);
        rd32(5'h14, d); check(d == 32'h1, "R8 one queued", d, 32'h1);
        tx_byte(8'h02);
        rd32(5'h14, d); check(d == 32'h0, "R8 at threshold", d, 32'h0);

        // R5 full flag and dropped write
        for (int i = 3; i <= 8; i++) tx_byte(8'(i));
        rd32(5'h00, d); check(d == 32'h8000_0000, "R5 full flag", d, 32'h8000_0000);
        wr32(5'h00, 32'h99);
        rd32(5'h00, d); check(d == 32'h8000_0000, "R5 still full", d, 32'h8000_0000);
        wr32(5'h08, 32'h1);
        repeat (450) @(negedge clk);
        check(txq.size() == 0, "R5 eight frames sent", txq.size(), 0);
        rd32(5'h00, d); check(d == 32'h0, "R5 not full", d, 32'h0);

        // R6 receive and pop
        wr32(5'h0C, 32'h1);
        send_byte(8'h5A);
        rd32(5'h04, d); check(d == 32'h5A, "R6 received byte", d, 32'h5A);
        rd32(5'h04, d); check(d[31] == 1'b1, "R6 empty flag", d, 32'h8000_0000);

        // R9 receive watermark, threshold 1
        wr32(5'h0C, 32'h0001_0001);
        send_byte(8'h61);
        rd32(5'h14, d); check(d[1] == 1'b0, "R9 at threshold", d, 32'h0);
        send_byte(8'h62);
        rd32(5'h14, d); check(d[1] == 1'b1, "R9 above threshold", d, 32'h2);
        wr32(5'h10, 32'h2);
        check(irq == 1'b1, "R10 receive irq", {31'b0, irq}, 32'h1);
        wr32(5'h10, 32'h0);
        rd32(5'h04, d); check(d == 32'h61, "R6 order first", d, 32'h61);
        rd32(5'h04, d); check(d == 32'h62, "R6 order second", d, 32'h62);

        // R7 overflow
        wr32(5'h0C, 32'h1);
        for (int i = 0; i < 9; i++) send_byte(8'h10 + 8'(i));
        for (int i = 0; i < 8; i++) begin
            rd32(5'h04, d);
            check(d == 32'h10 + 32'(i), "R7 kept byte", d, 32'h10 + 32'(i));
        end
        rd32(5'h04, d); check(d[31] == 1'b1, "R7 extra discarded", d, 32'h8000_0000);

        // R11 receiver disabled
        wr32(5'h0C, 32'h0);
        send_byte(8'h77);
        rd32(5'h04, d); check(d[31] == 1'b1, "R11 frame ignored", d, 32'h8000_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule